// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 32-bit memory address of an operand for two register-indirect addressing modes of a 32-bit processor. In the displacement mode it adds a signed 16-bit constant to an address register. In the indexed mode it adds three terms: an address register, a signed 8-bit constant and an index register. The index register is sign-extended and scaled.

A request carries the 3-bit mode field, the 3-bit register field and one 16-bit extension word. The block drives two combinational read ports into the register file. One is the base port, which selects an address register. The other is the index port, which selects either a data register or an address register. A request is taken on a cycle where valid and ready are both high. The registered result appears on the next cycle with its own valid. A new request may be taken on every cycle. A mode value the block does not support gives a one-cycle unsupported flag in place of an address.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high, `req_ready`, `out_valid` and `out_unsup` are low. From the first clock edge after `rst` falls, `req_ready` is high.
- R2: A request accepted with mode 3'b101 gives, one cycle later, `out_valid`=1 and `out_addr` = base register + the 16-bit extension word sign-extended to 32 bits.
- R3: The register field of the request selects the base address register. `base_sel` equals `req_reg`, and the value returned on `base_data` is the one used.
- R4: In mode 3'b110 the displacement is extension bits [7:0], sign-extended to 32 bits.
- R5: In mode 3'b110, extension bit 15 picks the index register type (0 = data register, 1 = address register). Bits [14:12] give its number. These appear on `idx_is_areg` and `idx_sel`.
- R6: Extension bit 11 sets the index size. With 0, index bits [15:0] are sign-extended to 32 bits. With 1, all 32 bits are used.
- R7: Extension bits [10:9] set the scale: 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8. The scale is a left shift applied after sign extension.
- R8: All sums wrap modulo 2^32.
- R9: A request with any mode other than 3'b101 or 3'b110 gives, one cycle later, `out_unsup`=1, `out_valid`=0 and `out_addr`=0. `out_valid` and `out_unsup` are never high together.
- R10: Requests on consecutive cycles each produce their result on the following cycle, in order. A cycle with no request gives `out_valid`=0 and `out_unsup`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 3 | Addressing mode field |
| req_reg | input | 3 | Base address register number |
| req_ext | input | 16 | Extension word |
| base_sel | output | 3 | Base read port: address register number |
| base_data | input | 32 | Base read port: register contents |
| idx_is_areg | output | 1 | Index read port: 1 selects an address register, 0 a data register |
| idx_sel | output | 3 | Index read port: register number |
| idx_data | input | 32 | Index read port: register contents |
| out_valid | output | 1 | Address result valid |
| out_addr | output | 32 | Computed operand address |
| out_unsup | output | 1 | Previous request had an unsupported mode |

## Verification
The hardest case to reach is one word-sized index whose low half is negative while its upper half is non-zero, combined with the largest scale. That value only shows whether the sign extension comes before the shift and whether the upper half is dropped. The bench loads every data register with such a value and sweeps the size and scale bits over it. Wrap-around needs a base register near the top of the address space, and one address register is loaded with such a value. Back-to-back requests with different modes check that each result follows its own request.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    MODE_DISP  = 3'b101,
    MODE_INDEX = 3'b110
  } ea_mode_e;
endpackage

// File: rtl/ea_index_term.sv
module ea_index_term #(
  parameter int AW      = 32,
  parameter int SHORT_W = 16,
  parameter int SCALE_W = 2
) (
  input  logic [AW-1:0]      raw,
  input  logic               long_sel,
  input  logic [SCALE_W-1:0] scale,
  output logic [AW-1:0]      term
);
  localparam int SCALE_N = 1 << SCALE_W;

  logic [AW-1:0] extended;
  logic [AW-1:0] shifted [SCALE_N];

  always_comb begin
    if (long_sel) extended = raw;
    else          extended = {{(AW-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
  end

  for (genvar s = 0; s < SCALE_N; s++) begin : g_shift
    assign shifted[s] = extended << s;
  end

  assign term = shifted[scale];
endmodule

// File: rtl/ea_disp_sel.sv
module ea_disp_sel #(
  parameter int AW      = 32,
  parameter int EXT_W   = 16,
  parameter int SDISP_W = 8
) (
  input  logic [EXT_W-1:0] ext,
  input  logic             short_form,
  output logic [AW-1:0]    disp
);
  logic [AW-1:0] wide_d;
  logic [AW-1:0] narrow_d;

  assign wide_d   = {{(AW-EXT_W){ext[EXT_W-1]}}, ext};
  assign narrow_d = {{(AW-SDISP_W){ext[SDISP_W-1]}}, ext[SDISP_W-1:0]};
  assign disp     = short_form ? narrow_d : wide_d;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW      = 32,
  parameter int EXT_W   = 16,
  parameter int SDISP_W = 8,
  parameter int RSEL_W  = 3,
  parameter int SCALE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [RSEL_W-1:0] req_reg,
  input  logic [EXT_W-1:0]  req_ext,
  output logic [RSEL_W-1:0] base_sel,
  input  logic [AW-1:0]     base_data,
  output logic              idx_is_areg,
  output logic [RSEL_W-1:0] idx_sel,
  input  logic [AW-1:0]     idx_data,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic              out_unsup
);
  localparam int TYPE_BIT = EXT_W - 1;
  localparam int NUM_HI   = TYPE_BIT - 1;
  localparam int SIZE_BIT = NUM_HI - RSEL_W;
  localparam int SCALE_HI = SIZE_BIT - 1;

  logic          accept;
  logic          is_disp;
  logic          is_index;
  logic          supported;
  logic [AW-1:0] disp;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] sum;

  assign base_sel    = req_reg;
  assign idx_is_areg = req_ext[TYPE_BIT];
  assign idx_sel     = req_ext[NUM_HI -: RSEL_W];

  assign accept    = req_valid && req_ready;
  assign is_disp   = (req_mode == MODE_DISP);
  assign is_index  = (req_mode == MODE_INDEX);
  assign supported = is_disp || is_index;

  ea_disp_sel #(
    .AW(AW), .EXT_W(EXT_W), .SDISP_W(SDISP_W)
  ) u_disp (
    .ext(req_ext),
    .short_form(is_index),
    .disp(disp)
  );

  ea_index_term #(
    .AW(AW), .SHORT_W(EXT_W), .SCALE_W(SCALE_W)
  ) u_index (
    .raw(idx_data),
    .long_sel(req_ext[SIZE_BIT]),
    .scale(req_ext[SCALE_HI -: SCALE_W]),
    .term(idx_term)
  );

  assign sum = base_data + disp + (is_index ? idx_term : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      out_valid <= 1'b0;
      out_unsup <= 1'b0;
      out_addr  <= '0;
    end else begin
      req_ready <= 1'b1;
      out_valid <= accept && supported;
      out_unsup <= accept && !supported;
      if (accept) out_addr <= supported ? sum : '0;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW     = 32,
  parameter int EXT_W  = 16,
  parameter int RSEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_mode,
  input logic [EXT_W-1:0]  req_ext,
  input logic [AW-1:0]     base_data,
  input logic              out_valid,
  input logic [AW-1:0]     out_addr,
  input logic              out_unsup
);
  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> req_ready);

  // R2
  disp_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mode == 3'b101) |=>
      (out_valid && out_addr == $past(base_data + {{(AW-EXT_W){req_ext[EXT_W-1]}}, req_ext})));

  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_unsup));

  // R9
  unsup_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_unsup |-> (out_addr == '0 && $past(req_mode != 3'b101 && req_mode != 3'b110)));

  // R10
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_unsup) |-> $past(req_valid && req_ready));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> (!out_valid && !out_unsup));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .EXT_W(EXT_W), .RSEL_W(RSEL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .req_ext(req_ext), .base_data(base_data),
  .out_valid(out_valid), .out_addr(out_addr), .out_unsup(out_unsup)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = 3'b000;
  logic [2:0]  req_reg = 3'b000;
  logic [15:0] req_ext = 16'h0000;
  logic [2:0]  base_sel;
  logic [31:0] base_data;
  logic        idx_is_areg;
  logic [2:0]  idx_sel;
  logic [31:0] idx_data;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_unsup;

  logic [31:0] areg [8];
  logic [31:0] dreg [8];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign base_data = areg[base_sel];
  assign idx_data  = idx_is_areg ? areg[idx_sel] : dreg[idx_sel];

  ea_gen u_ea_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_reg(req_reg), .req_ext(req_ext),
    .base_sel(base_sel), .base_data(base_data),
    .idx_is_areg(idx_is_areg), .idx_sel(idx_sel), .idx_data(idx_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_unsup(out_unsup)
  );

  function automatic logic [31:0] expect_ea(input logic [2:0] m, input logic [2:0] r,
                                            input logic [15:0] e);
    logic [31:0] ix;
    if (m == 3'b101) return areg[r] + {{16{e[15]}}, e};
    ix = e[15] ? areg[e[14:12]] : dreg[e[14:12]];
    if (!e[11]) ix = {{16{ix[15]}}, ix[15:0]};
    ix = ix << e[10:9];
    return areg[r] + {{24{e[7]}}, e[7:0]} + ix;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [2:0] r, input logic [15:0] e);
    req_valid = 1'b1; req_mode = m; req_reg = r; req_ext = e;
  endtask

  task automatic one_req(input string tag, input logic [2:0] m, input logic [2:0] r,
                         input logic [15:0] e);
    @(negedge clk);
    drive(m, r, e);
    @(negedge clk);
    req_valid = 1'b0;
    if (m == 3'b101 || m == 3'b110) begin
      check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
      check({tag, " addr"}, out_addr, expect_ea(m, r, e));
    end else begin
      check({tag, " unsup"}, {31'd0, out_unsup}, 32'd1);
      check({tag, " valid low"}, {31'd0, out_valid}, 32'd0);
      check({tag, " addr zero"}, out_addr, 32'd0);
    end
  endtask

  task automatic t_reset();
    // R1
    check("R1 ready in reset", {31'd0, req_ready}, 32'd0);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 unsup in reset", {31'd0, out_unsup}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_disp();
    one_req("R2 R3 positive disp", 3'b101, 3'd3, 16'h1234);
    one_req("R2 R3 negative disp", 3'b101, 3'd6, 16'hFF00);
    check("R3 base_sel follows reg", {29'd0, base_sel}, 32'd6);
  endtask

  task automatic t_index();
    one_req("R4 negative short disp", 3'b110, 3'd1, 16'h0080);
    one_req("R4 upper ext ignored in disp", 3'b110, 3'd1, 16'h0000 | 16'h007F);
    one_req("R5 R6 data word idx", 3'b110, 3'd2, 16'h3010);
    one_req("R5 R6 data long idx", 3'b110, 3'd2, 16'h3810);
    one_req("R5 addr reg idx", 3'b110, 3'd0, 16'hD805);
    for (int s = 0; s < 4; s++) begin
      one_req("R7 word scale", 3'b110, 3'd4, 16'h5000 | 16'(s << 9));
      one_req("R7 long scale", 3'b110, 3'd4, 16'h5800 | 16'(s << 9));
    end
    @(negedge clk);
    drive(3'b110, 3'd0, 16'hA000);
    #1;
    check("R5 idx_is_areg", {31'd0, idx_is_areg}, 32'd1);
    check("R5 idx_sel", {29'd0, idx_sel}, 32'd2);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_wrap();
    one_req("R8 wrap disp", 3'b101, 3'd7, 16'h0020);
    one_req("R8 wrap index", 3'b110, 3'd7, 16'hF87F);
  endtask

  task automatic t_unsup();
    one_req("R9 mode 000", 3'b000, 3'd1, 16'h1234);
    one_req("R9 mode 111", 3'b111, 3'd1, 16'h1234);
  endtask

  task automatic t_stream();
    @(negedge clk); drive(3'b101, 3'd1, 16'h0004);
    @(negedge clk); drive(3'b110, 3'd2, 16'h1602);
    check("R10 first of stream", out_addr, expect_ea(3'b101, 3'd1, 16'h0004));
    @(negedge clk); drive(3'b011, 3'd2, 16'h0000);
    check("R10 second of stream", out_addr, expect_ea(3'b110, 3'd2, 16'h1602));
    check("R10 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk); req_valid = 1'b0;
    check("R10 third unsup", {31'd0, out_unsup}, 32'd1);
    @(negedge clk);
    check("R10 idle valid low", {31'd0, out_valid}, 32'd0);
    check("R10 idle unsup low", {31'd0, out_unsup}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      areg[i] = 32'h0001_0000 * (i + 1) + 32'h40;
      dreg[i] = 32'h1230_0000 + (i << 16) + 32'hFFF0 - i;
    end
    areg[7] = 32'hFFFF_FFF0;
    areg[5] = 32'h0000_8003;
    @(negedge clk); @(negedge clk);
    t_reset();
    t_disp();
    t_index();
    t_wrap();
    t_unsup();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule